// File: doc/BRIEF.md
# UART Receive Buffer with Per-Character Status

This block is the receive-side store of one UART channel. The receiver's shift logic delivers each assembled character together with three error flags: parity error, framing error and break. The block keeps them in an eight-entry first-in first-out store. A CPU register interface reads characters out through a data port, and each data read removes the oldest character. The error flags are shown continuously on separate outputs, so looking at them never consumes anything.

When the store is full, one further character waits in a holding stage that stands for the receiver shift register. If yet another character completes, the new one replaces the waiting one and a sticky overrun flag is raised. The characters already stored are not touched. Status is reported in one of two ways. In character mode it is the flags of the oldest stored character. In block mode it is the accumulated OR of the flags since the last error-reset command.

An optional flow-control output, active low, tells the remote transmitter to pause when a new start bit arrives while the store is full. It releases on its own once room appears. Command strobes enable, disable and reset the receiver.

Top module: `uart_rx_buffer`

## Requirements
- R1: The store holds up to DEPTH (8) characters. `rx_ready_o` is high while at least one is stored. `fifo_full_o` is high while DEPTH are stored. Characters leave in arrival order.
- R2: A character that completes while the store is full waits in the holding stage. A data read that frees a slot moves the waiting character into the store on the same clock edge, so `fifo_full_o` stays high.
- R3: A character that completes while both the store and the holding stage are occupied, with no read on that edge, replaces the waiting character and sets `overrun_o`. The stored characters are unchanged.
- R4: `overrun_o` is never stored with a character. It stays set until an `err_reset_i` strobe, and a new overrun on the same edge wins over the clear.
- R5: Each stored character keeps its flags. In character mode (`block_mode_i`=0) the outputs `stat_perr_o`, `stat_ferr_o` and `stat_brk_o` show the flags of the oldest stored character, and all three are 0 when the store is empty.
- R6: In block mode (`block_mode_i`=1) each status output is the OR of that flag over every character that has been oldest in the store since the last `err_reset_i` or `rx_reset_i`, including the current oldest.
- R7: The status outputs can be observed without removing anything. Only `data_rd_i` removes the oldest character, and its data appears on `rd_data_o` one clock after the read edge.
- R8: A data read while the store is empty leaves `rd_data_o` and the store unchanged.
- R9: With `flow_ctl_i`=1, a `start_bit_i` while the store is full drives `rts_no` high on the next edge. `rts_no` returns low on the first edge at which the store is not full. With `flow_ctl_i`=0, `rts_no` is low.
- R10: `rx_disable_i` discards the waiting character and blocks new characters until `rx_enable_i`. Stored characters and their status stay readable.
- R11: `rx_reset_i` empties the store, discards the waiting character, clears the block-mode accumulation, and leaves the receiver disabled until `rx_enable_i`.
- R12: After `rst_ni` the receiver is disabled, and `rx_ready_o`, `fifo_full_o`, `overrun_o`, `rts_no`, `rd_data_o` and all status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_valid_i | input | 1 | Assembled character completes this cycle |
| char_data_i | input | DATA_W | Character data |
| char_perr_i | input | 1 | Parity error flag of the character |
| char_ferr_i | input | 1 | Framing error flag of the character |
| char_brk_i | input | 1 | Received break flag of the character |
| start_bit_i | input | 1 | Valid start bit detected |
| data_rd_i | input | 1 | Data read strobe, removes oldest character |
| err_reset_i | input | 1 | Error-reset command |
| rx_reset_i | input | 1 | Receiver reset command |
| rx_enable_i | input | 1 | Receiver enable command |
| rx_disable_i | input | 1 | Receiver disable command |
| block_mode_i | input | 1 | 1 = block status, 0 = character status |
| flow_ctl_i | input | 1 | Enable automatic receive flow control |
| rd_data_o | output | DATA_W | Data of the last removed character |
| rx_ready_o | output | 1 | At least one character stored |
| fifo_full_o | output | 1 | Store full |
| overrun_o | output | 1 | Sticky overrun flag |
| stat_perr_o | output | 1 | Reported parity error |
| stat_ferr_o | output | 1 | Reported framing error |
| stat_brk_o | output | 1 | Reported break |
| rts_no | output | 1 | Request to send, active low |

## Verification
Some rules are checked by the assertions on every cycle. These are: the holding stage is only occupied while the store is full; overrun stays set until an error reset; ready never drops without a read or reset; an empty read leaves the data output alone; the flow-control output reacts to start bits and to free room; and disable and reset clear the holding stage. Other behaviour is only visible through the bench's scenarios. This covers the order in which the ninth and tenth characters leave after an overrun, the block-mode OR over a run of characters, and the requirement that characters arriving while the receiver is disabled are ignored. The bench's reference model follows these rules through random traffic, and directed sequences press on the full and overrun boundary.

// File: rtl/uart_rxbuf_pkg.sv
package uart_rxbuf_pkg;
  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_stat_t;
  localparam int STAT_W = $bits(rx_stat_t);
endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
  parameter int DEPTH = 8,
  parameter int W     = 11,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic [W-1:0]  push_word_i,
  input  logic          pop_i,
  output logic [W-1:0]  top_o,
  output logic [CW-1:0] count_o,
  output logic [W-1:0]  rd_word_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign top_o = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= push_word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count_o   <= '0;
      rd_word_o <= '0;
    end else if (clear_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i) begin
        rd_ptr    <= nxt(rd_ptr);
        rd_word_o <= mem[rd_ptr];
      end
      case ({push_i, pop_i})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end
endmodule

// File: rtl/rxbuf_status.sv
module rxbuf_status
  import uart_rxbuf_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clear_i,
  input  logic     block_i,
  input  logic     top_vld_i,
  input  rx_stat_t top_stat_i,
  output rx_stat_t stat_o
);
  rx_stat_t acc_q, top_now;

  assign top_now = top_vld_i ? top_stat_i : '0;
  assign stat_o  = block_i ? (acc_q | top_now) : top_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else              acc_q <= acc_q | top_now;
  end
endmodule

// File: rtl/rxbuf_rts.sv
module rxbuf_rts (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flow_i,
  input  logic start_i,
  input  logic full_i,
  output logic rts_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rts_no <= 1'b0;
    else if (!flow_i)            rts_no <= 1'b0;
    else if (full_i && start_i)  rts_no <= 1'b1;
    else if (!full_i)            rts_no <= 1'b0;
  end
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rxbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_valid_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              char_perr_i,
  input  logic              char_ferr_i,
  input  logic              char_brk_i,
  input  logic              start_bit_i,
  input  logic              data_rd_i,
  input  logic              err_reset_i,
  input  logic              rx_reset_i,
  input  logic              rx_enable_i,
  input  logic              rx_disable_i,
  input  logic              block_mode_i,
  input  logic              flow_ctl_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rx_ready_o,
  output logic              fifo_full_o,
  output logic              overrun_o,
  output logic              stat_perr_o,
  output logic              stat_ferr_o,
  output logic              stat_brk_o,
  output logic              rts_no
);
  localparam int W  = DATA_W + STAT_W;
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  new_word, hold_word, push_word, top_word, rd_word;
  logic          on_q, hold_vld;
  logic          pop, accept, space, hmove, push, ovr_set;
  rx_stat_t      stat;

  assign new_word    = {char_brk_i, char_ferr_i, char_perr_i, char_data_i};
  assign rx_ready_o  = (cnt != '0);
  assign fifo_full_o = (cnt == CW'(DEPTH));
  assign pop         = data_rd_i && rx_ready_o && !rx_reset_i;
  assign accept      = char_valid_i && on_q && !rx_disable_i && !rx_reset_i;
  assign space       = !fifo_full_o || pop;
  assign hmove       = hold_vld && pop;  // waiting char takes the freed slot
  assign push        = hmove || (accept && !hold_vld && space);
  assign push_word   = hmove ? hold_word : new_word;
  assign ovr_set     = accept && hold_vld && !pop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          on_q <= 1'b0;
    else if (rx_reset_i || rx_disable_i)  on_q <= 1'b0;
    else if (rx_enable_i)                 on_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld  <= 1'b0;
      hold_word <= '0;
    end else if (rx_reset_i || rx_disable_i) begin
      hold_vld  <= 1'b0;
    end else if (accept && (hold_vld || !space)) begin
      hold_vld  <= 1'b1;
      hold_word <= new_word;
    end else if (hmove) begin
      hold_vld  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          overrun_o <= 1'b0;
    else if (ovr_set)     overrun_o <= 1'b1;
    else if (err_reset_i) overrun_o <= 1'b0;
  end

  rxbuf_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (rx_reset_i),
    .push_i     (push),
    .push_word_i(push_word),
    .pop_i      (pop),
    .top_o      (top_word),
    .count_o    (cnt),
    .rd_word_o  (rd_word)
  );

  rxbuf_status u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (err_reset_i || rx_reset_i),
    .block_i   (block_mode_i),
    .top_vld_i (rx_ready_o),
    .top_stat_i(rx_stat_t'(top_word[W-1 -: STAT_W])),
    .stat_o    (stat)
  );

  rxbuf_rts u_rts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flow_i (flow_ctl_i),
    .start_i(start_bit_i),
    .full_i (fifo_full_o),
    .rts_no (rts_no)
  );

  assign rd_data_o   = rd_word[DATA_W-1:0];
  assign stat_perr_o = stat.perr;
  assign stat_ferr_o = stat.ferr;
  assign stat_brk_o  = stat.brk;
endmodule

// File: rtl/uart_rx_buffer_chk.sv
module uart_rx_buffer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_bit_i,
  input logic              data_rd_i,
  input logic              err_reset_i,
  input logic              rx_reset_i,
  input logic              rx_disable_i,
  input logic              block_mode_i,
  input logic              flow_ctl_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rx_ready_o,
  input logic              fifo_full_o,
  input logic              overrun_o,
  input logic              stat_perr_o,
  input logic              stat_ferr_o,
  input logic              stat_brk_o,
  input logic              rts_no,
  input logic              hold_vld
);
  AST_HOLD_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_vld |-> fifo_full_o); // R2
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !err_reset_i) |=> overrun_o); // R4
  AST_CHAR_EMPTY_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!block_mode_i && !rx_ready_o) |-> !(stat_perr_o || stat_ferr_o || stat_brk_o)); // R5
  AST_NO_POP_WITHOUT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ready_o && !data_rd_i && !rx_reset_i) |=> rx_ready_o); // R7
  AST_EMPTY_READ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && !rx_ready_o) |=> $stable(rd_data_o)); // R8
  AST_RTS_NEGATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flow_ctl_i && start_bit_i && fifo_full_o) |=> rts_no); // R9
  AST_RTS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rts_no && !fifo_full_o) |=> !rts_no); // R9
  AST_DISABLE_DROPS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_disable_i |=> !hold_vld); // R10
  AST_RX_RESET_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_reset_i |=> (!rx_ready_o && !hold_vld)); // R11
endmodule

bind uart_rx_buffer uart_rx_buffer_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_uart_rx_buffer.sv
module sim_uart_rx_buffer;
  localparam int DW = 8;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cv = 0, pe = 0, fe = 0, bk = 0, sb = 0, rd = 0, er = 0, rr = 0, en = 0, ds = 0, bm = 0, fc = 0;
  logic [DW-1:0] cd = '0;
  logic [DW-1:0] rd_data;
  logic rdy, full, ovr, sp, sf, sbk, rts;

  always #5 clk = ~clk;

  uart_rx_buffer #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .char_valid_i(cv), .char_data_i(cd),
    .char_perr_i(pe), .char_ferr_i(fe), .char_brk_i(bk), .start_bit_i(sb),
    .data_rd_i(rd), .err_reset_i(er), .rx_reset_i(rr), .rx_enable_i(en),
    .rx_disable_i(ds), .block_mode_i(bm), .flow_ctl_i(fc), .rd_data_o(rd_data),
    .rx_ready_o(rdy), .fifo_full_o(full), .overrun_o(ovr), .stat_perr_o(sp),
    .stat_ferr_o(sf), .stat_brk_o(sbk), .rts_no(rts));

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic [10:0] q[$];
  logic [10:0] hold_m;
  bit hold_v = 0, ovr_m = 0, on_m = 0, rts_m = 0;
  logic [2:0] acc_m = '0;
  logic [DW-1:0] rdd_m = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_stat();
    logic [2:0] top = (q.size() != 0) ? q[0][10:8] : 3'b000;
    return bm ? (acc_m | top) : top;
  endfunction

  task automatic model_edge();
    bit ne = q.size() != 0;
    bit fl = q.size() == DEPTH;
    bit pop = rd && ne && !rr;
    bit acc_in = cv && on_m && !ds && !rr;
    bit oset = 0;
    logic [10:0] nw = {bk, fe, pe, cd};
    if (er || rr) acc_m = '0; else if (ne) acc_m = acc_m | q[0][10:8];
    if (!fc) rts_m = 0; else if (fl && sb) rts_m = 1; else if (!fl) rts_m = 0;
    if (pop) begin rdd_m = q[0][7:0]; void'(q.pop_front()); end
    if (rr) begin q.delete(); hold_v = 0; end
    else begin
      if (hold_v && pop) begin q.push_back(hold_m); hold_v = 0; end
      if (acc_in) begin
        if (q.size() < DEPTH && !hold_v) q.push_back(nw);
        else if (hold_v) begin hold_m = nw; oset = 1; end
        else begin hold_m = nw; hold_v = 1; end
      end
      if (ds) hold_v = 0;
    end
    if (oset) ovr_m = 1; else if (er) ovr_m = 0;
    if (rr || ds) on_m = 0; else if (en) on_m = 1;
  endtask

  task automatic compare_all();
    chk("R1 rx_ready", 32'(rdy), 32'(q.size() != 0));
    chk("R1 fifo_full", 32'(full), 32'(q.size() == DEPTH));
    chk("R3/R4 overrun", 32'(ovr), 32'(ovr_m));
    chk(bm ? "R6 block status" : "R5 char status", 32'({sbk, sf, sp}), 32'(exp_stat()));
    chk("R7 rd_data", 32'(rd_data), 32'(rdd_m));
    chk("R9 rts", 32'(rts), 32'(rts_m));
  endtask

  task automatic idle();
    cv = 0; sb = 0; rd = 0; er = 0; rr = 0; en = 0; ds = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic put(logic [7:0] d, logic [2:0] f);
    cv = 1; cd = d; {bk, fe, pe} = f; tick();
  endtask

  task automatic get();
    rd = 1; tick();
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    // R12 reset state
    chk("R12 ready", 32'(rdy), 0); chk("R12 full", 32'(full), 0);
    chk("R12 overrun", 32'(ovr), 0); chk("R12 rts", 32'(rts), 0);
    chk("R12 rd_data", 32'(rd_data), 0); chk("R12 stat", 32'({sbk, sf, sp}), 0);
    rst_n = 1;
    @(negedge clk);
    // R10/R12 receiver starts disabled: char ignored
    put(8'h55, 3'b000);
    chk("R10 disabled ignores char", 32'(rdy), 0);
    en = 1; tick();
    // fill 10: 8 stored, 9th waits, 10th overruns
    for (int i = 1; i <= 10; i++) put(8'(i), 3'(i));
    chk("R3 overrun set", 32'(ovr), 1);
    chk("R1 full", 32'(full), 1);
    get();
    chk("R2 slot refilled by waiting char", 32'(full), 1);
    chk("R1 first out", 32'(rd_data), 1);
    for (int i = 2; i <= 9; i++) begin
      get();
      chk(i == 9 ? "R3 latest replaces waiting" : "R1 order", 32'(rd_data), (i == 9) ? 10 : i);
    end
    chk("R1 empty", 32'(rdy), 0);
    get();
    chk("R8 empty read keeps data", 32'(rd_data), 10);
    chk("R4 overrun sticky", 32'(ovr), 1);
    er = 1; tick();
    chk("R4 overrun cleared", 32'(ovr), 0);
    // R6 block mode
    bm = 1;
    put(8'h21, 3'b001); put(8'h22, 3'b100); get();
    chk("R6 block OR", 32'({sbk, sf, sp}), 3'b101);
    bm = 0; @(negedge clk);
    chk("R5 char top", 32'({sbk, sf, sp}), 3'b100);
    get();
    // R10 disable drops waiting char, keeps stored
    for (int i = 0; i < 9; i++) put(8'(8'h40 + i), 3'b010);
    ds = 1; tick();
    put(8'h77, 3'b000);
    chk("R10 stored kept", 32'(full), 1);
    en = 1; tick();
    for (int i = 0; i < 8; i++) get();
    chk("R10 waiting char discarded", 32'(rdy), 0);
    // R11 receiver reset
    put(8'h11, 3'b111); put(8'h12, 3'b000);
    rr = 1; tick();
    chk("R11 empty", 32'(rdy), 0);
    chk("R11 status clear", 32'({sbk, sf, sp}), 0);
    put(8'h13, 3'b000);
    chk("R11 needs enable", 32'(rdy), 0);
    en = 1; tick();
    // R9 directed
    fc = 1;
    for (int i = 0; i < 8; i++) put(8'(i), 3'b000);
    sb = 1; tick();
    chk("R9 rts negated", 32'(rts), 1);
    get(); tick();
    chk("R9 rts reasserted", 32'(rts), 0);
    // random traffic against model
    for (int n = 0; n < 4000; n++) begin
      cv = ($urandom % 100) < 45; cd = 8'($urandom); {bk, fe, pe} = 3'($urandom);
      sb = ($urandom % 100) < 20; rd = ($urandom % 100) < 30;
      er = ($urandom % 100) < 4; rr = ($urandom % 1000) < 5;
      ds = ($urandom % 1000) < 10; en = ($urandom % 100) < 10;
      if ($urandom % 100 < 3) bm = ~bm;
      if ($urandom % 100 < 2) fc = ~fc;
      tick();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule